// File: doc/BRIEF.md
# Two-Level Lookup-Table Logic Cell

This block is a configurable logic cell whose behaviour is held entirely in truth-table bits. Two first-level tables, each indexed by four cell inputs, produce two results. A second-level table with three index bits combines those two results with one extra cell input. A single cell can therefore realise two unrelated 4-variable functions together with a 3-variable function of them, any 5-variable function, or selected 9-variable functions such as odd parity over nine inputs. Two combinational outputs and two registered outputs each pick one of the three table results.

All table contents and output selections sit in one serial configuration chain. While the configuration enable is high, one bit enters per clock and the oldest bit leaves on a serial output, so cells can be chained and loaded from external storage at start-up. While the chain is shifting, the two flip-flops hold their values.

Top module: `clb_cell`

## Requirements
- R1: After the asynchronous active-low reset, every configuration bit is 0, both flip-flops are 0, and all outputs (x_out, y_out, xq_out, yq_out, cfg_dout) read 0.
- R2: While cfg_en is high, each clock edge shifts cfg_din into the 48-bit chain; cfg_dout shows the bit that entered 48 shifts earlier. Load order: first-level table F entry 15 down to entry 0, then table G entry 15 down to 0, then table H entry 7 down to 0, then four 2-bit selects (x_out, y_out, xq_out, yq_out), each sent MSB first.
- R3: Table F's result is its entry indexed by f_in read as an unsigned number; table G's result is its entry indexed by g_in.
- R4: Table H's result is its entry indexed by {h1_in, G result, F result}, with h1_in as index bit 2 and the F result as bit 0.
- R5: x_out and y_out are combinational; select value 0 picks the F result, 1 the G result, 2 or 3 the H result.
- R6: When cfg_en is low, sr is low and ce is high, each flip-flop captures the result named by its own select (same encoding as R5) on the clock edge; the registered output shows it after that edge.
- R7: When cfg_en, sr and ce are all low, both flip-flops keep their values whatever the data inputs do.
- R8: When cfg_en is low and sr is high, both flip-flops clear to 0 on the clock edge, regardless of ce.
- R9: While cfg_en is high both flip-flops hold, sr and ce are ignored; while cfg_en is low the configuration is unchanged.
- R10: Loaded with F and G covering the two halves of a 5-variable truth table and H set to the 2:1 multiplexer 8'hCA, x_out (select 2) equals the 5-variable function of {h1_in, f_in} when f_in equals g_in; loaded with F and G as 4-input parity (16'h6996) and H as 3-input parity (8'h96), x_out is the odd parity of all nine inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (oldest bit of the chain) |
| f_in | input | 4 | Index inputs of table F |
| g_in | input | 4 | Index inputs of table G |
| h1_in | input | 1 | Extra index input of table H |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Flip-flop synchronous clear |
| x_out | output | 1 | Combinational output, first selector |
| y_out | output | 1 | Combinational output, second selector |
| xq_out | output | 1 | Registered output, first flip-flop |
| yq_out | output | 1 | Registered output, second flip-flop |

## Verification
The bench attacks the bit order of the serial load: a design that reversed a table or swapped the F and G fields would answer with the mirrored truth table, which the exhaustive sweeps over all 256 (f_in, g_in) pairs with h1_in toggling expose. The index order of table H matters as much, since a swapped F/G position leaves parity intact but breaks the 5-variable multiplexer case. Priority between cfg_en, sr and ce is probed by asserting sr and ce during a load and sr with ce low; a design with the wrong priority would clear or update its flip-flops mid-load or ignore the clear. The serial output is compared on every cycle across two back-to-back loads, so an off-by-one chain length shows as cfg_dout leading or lagging the previous configuration.

// File: rtl/clb_pkg.sv
package clb_pkg;

    localparam int CLB_LUT_K = 4;
    localparam int CLB_H_K   = 3;
    localparam int SEL_W     = 2;
    localparam int NUM_SEL   = 4;
    localparam int NUM_FF    = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_F     = 2'd0,
        SRC_G     = 2'd1,
        SRC_H     = 2'd2,
        SRC_H_ALT = 2'd3
    } src_e;

    // order inside the chain tail: x, y, xq, yq (x is most significant)
    typedef struct packed {
        src_e x_sel;
        src_e y_sel;
        src_e xq_src;
        src_e yq_src;
    } sel_cfg_t;

    function automatic logic pick_src(input src_e s, input logic f_v,
                                      input logic g_v, input logic h_v);
        logic r;
        case (s)
            SRC_F:   r = f_v;
            SRC_G:   r = g_v;
            default: r = h_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic             dout,
    output logic [WIDTH-1:0] cfg
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) begin
            chain_d.bits = {chain_q.bits[WIDTH-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign cfg  = chain_q.bits;
    assign dout = chain_q.bits[WIDTH-1];

    // R2: a shift lands the input bit at the chain entry
    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain_q.bits[0] == $past(din)));

    // R9: configuration is frozen when not shifting
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q.bits));

endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4,
    localparam int ENTRIES = 1 << K
) (
    input  logic [ENTRIES-1:0] tab_bits,
    input  logic [K-1:0]       idx,
    output logic               out
);

    always_comb begin
        out = tab_bits[idx];
    end

endmodule

// File: rtl/clb_ff.sv
module clb_ff
    import clb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ce,
    input  logic sr,
    input  src_e src,
    input  logic f_val,
    input  logic g_val,
    input  logic h_val,
    output logic q
);

    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (!hold) begin
            if (sr) begin
                q_d = 1'b0;
            end else if (ce) begin
                q_d = pick_src(src, f_val, g_val, h_val);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;

    // R9: loading the chain freezes the register
    assert_hold_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q_q));

    // R8: clear wins over the enable
    assert_sr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && sr) |=> !q_q);

    // R7: enable low keeps the value
    assert_ce_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !sr && !ce) |=> $stable(q_q));

endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
#(
    parameter int LUT_K = CLB_LUT_K
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic             cfg_dout,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h1_in,
    input  logic             ce,
    input  logic             sr,
    output logic             x_out,
    output logic             y_out,
    output logic             xq_out,
    output logic             yq_out
);

    localparam int TAB_W    = 1 << LUT_K;
    localparam int H_W      = 1 << CLB_H_K;
    localparam int SEL_BITS = NUM_SEL * SEL_W;
    localparam int CFG_W    = 2 * TAB_W + H_W + SEL_BITS;

    logic [CFG_W-1:0] cfg_bits;
    logic [TAB_W-1:0] lvl1_tab [2];
    logic [LUT_K-1:0] lvl1_idx [2];
    logic             lvl1_res [2];
    logic [H_W-1:0]   h_tab;
    logic             h_res;
    sel_cfg_t         sel;
    src_e             ff_src   [NUM_FF];
    logic             ff_q     [NUM_FF];

    clb_cfg_chain #(.WIDTH(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .dout     (cfg_dout),
        .cfg      (cfg_bits)
    );

    // field layout follows the load order: F, G, H, selects
    assign lvl1_tab[0] = cfg_bits[CFG_W-1 -: TAB_W];
    assign lvl1_tab[1] = cfg_bits[CFG_W-1-TAB_W -: TAB_W];
    assign h_tab       = cfg_bits[SEL_BITS +: H_W];
    assign sel         = sel_cfg_t'(cfg_bits[SEL_BITS-1:0]);

    assign lvl1_idx[0] = f_in;
    assign lvl1_idx[1] = g_in;

    for (genvar i = 0; i < 2; i++) begin : g_lvl1
        clb_lut #(.K(LUT_K)) u_lut (
            .tab_bits (lvl1_tab[i]),
            .idx      (lvl1_idx[i]),
            .out      (lvl1_res[i])
        );
    end

    clb_lut #(.K(CLB_H_K)) u_lut_h (
        .tab_bits (h_tab),
        .idx      ({h1_in, lvl1_res[1], lvl1_res[0]}),
        .out      (h_res)
    );

    always_comb begin
        x_out = pick_src(sel.x_sel, lvl1_res[0], lvl1_res[1], h_res);
        y_out = pick_src(sel.y_sel, lvl1_res[0], lvl1_res[1], h_res);
    end

    assign ff_src[0] = sel.xq_src;
    assign ff_src[1] = sel.yq_src;

    for (genvar j = 0; j < NUM_FF; j++) begin : g_ff
        clb_ff u_ff (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (cfg_en),
            .ce    (ce),
            .sr    (sr),
            .src   (ff_src[j]),
            .f_val (lvl1_res[0]),
            .g_val (lvl1_res[1]),
            .h_val (h_res),
            .q     (ff_q[j])
        );
    end

    assign xq_out = ff_q[0];
    assign yq_out = ff_q[1];

    // R6: with a stable config, the register follows the combinational output of the same select
    assert_reg_tracks_comb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !sr && ce && sel.xq_src == sel.x_sel) |=> (xq_out == $past(x_out)));

endmodule

// File: tb/tb_clb_cell.sv
`timescale 1ns/1ps
module tb_clb_cell;

    logic       clk = 1'b0;
    logic       rst_n, cfg_en, cfg_din, ce, sr, h1;
    logic [3:0] fa, ga;
    logic       cfg_dout, x_out, y_out, xq_out, yq_out;

    int total = 0;
    int bad   = 0;

    bit mq[$];
    bit mxq, myq;

    always #5 clk = ~clk;

    clb_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .f_in(fa), .g_in(ga), .h1_in(h1), .ce(ce),
        .sr(sr), .x_out(x_out), .y_out(y_out), .xq_out(xq_out), .yq_out(yq_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference: queue holds bits in arrival order, oldest first
    function automatic bit m_f(input logic [3:0] a); return mq[15 - a]; endfunction
    function automatic bit m_g(input logic [3:0] a); return mq[31 - a]; endfunction
    function automatic bit m_h(input int i);         return mq[39 - i]; endfunction
    function automatic int m_sel(input int k);
        return 2 * int'(mq[40 + 2*k]) + int'(mq[41 + 2*k]);
    endfunction
    function automatic bit m_pick(input int s, input bit f, input bit g, input bit h);
        if (s == 0) return f;
        if (s == 1) return g;
        return h;
    endfunction

    task automatic run_cycle(input logic en, input logic din, input logic ce_i,
                             input logic sr_i, input logic [3:0] a,
                             input logic [3:0] b, input logic e);
        bit mf, mg, mh, nxq, nyq;
        cfg_en = en; cfg_din = din; ce = ce_i; sr = sr_i; fa = a; ga = b; h1 = e;
        #1;
        mf = m_f(a);
        mg = m_g(b);
        mh = m_h(4 * int'(e) + 2 * int'(mg) + int'(mf));
        chk("R5 x_out", x_out, m_pick(m_sel(0), mf, mg, mh));
        chk("R5 y_out", y_out, m_pick(m_sel(1), mf, mg, mh));
        chk("R6 xq_out", xq_out, mxq);
        chk("R6 yq_out", yq_out, myq);
        chk("R2 cfg_dout", cfg_dout, mq[0]);
        nxq = mxq; nyq = myq;
        if (!en) begin
            if (sr_i) begin
                nxq = 1'b0; nyq = 1'b0;
            end else if (ce_i) begin
                nxq = m_pick(m_sel(2), mf, mg, mh);
                nyq = m_pick(m_sel(3), mf, mg, mh);
            end
        end
        @(posedge clk);
        mxq = nxq; myq = nyq;
        if (en) begin
            mq.push_back(din);
            void'(mq.pop_front());
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] ft, input logic [15:0] gt, input logic [7:0] ht,
                        input logic [1:0] xs, input logic [1:0] ys,
                        input logic [1:0] xqs, input logic [1:0] yqs);
        logic [47:0] v;
        v = {ft, gt, ht, xs, ys, xqs, yqs};
        for (int i = 47; i >= 0; i--) begin
            // sr and ce toggled during the load must be ignored (R9)
            run_cycle(1'b1, v[i], i[0], i[1], 4'(i), 4'(i * 7), i[2]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       sx, sy;
        logic [31:0] f5;
        for (int i = 0; i < 48; i++) mq.push_back(1'b0);
        mxq = 0; myq = 0;
        rst_n = 0; cfg_en = 0; cfg_din = 0; ce = 0; sr = 0; h1 = 0; fa = 0; ga = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 x_out", x_out, 1'b0);
        chk("R1 y_out", y_out, 1'b0);
        chk("R1 xq_out", xq_out, 1'b0);
        chk("R1 yq_out", yq_out, 1'b0);
        chk("R1 cfg_dout", cfg_dout, 1'b0);
        rst_n = 1;

        // general config: x=F, y=H, xq=G, yq=F
        load(16'hA5C3, 16'h6E19, 8'hD2, 2'd0, 2'd2, 2'd1, 2'd0);
        for (int n = 0; n < 512; n++) begin
            logic [3:0] a, b;
            logic       e, fv, gv;
            a = n[3:0]; b = n[7:4]; e = n[8];
            run_cycle(1'b0, 1'b0, 1'b1, 1'b0, a, b, e);
            fv = 16'hA5C3 >> a;
            gv = 16'h6E19 >> b;
            // outputs just after the edge still reflect this cycle's inputs
            cfg_en = 0; fa = a; ga = b; h1 = e; #1;
            chk("R3 F lookup on x_out", x_out, fv);
            chk("R4 H index on y_out", y_out, 1'((8'hD2 >> {e, gv, fv})));
            chk("R6 xq captures G", xq_out, gv);
            chk("R6 yq captures F", yq_out, fv);
        end

        // R7: enable low holds
        sx = xq_out; sy = yq_out;
        for (int n = 0; n < 8; n++) run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 4'(n * 3), 4'(n * 5), n[0]);
        chk("R7 xq held", xq_out, sx);
        chk("R7 yq held", yq_out, sy);

        // drive a known 1 into both regs, then R8 clear with ce low
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0); // F[0]=1, G[0]=1
        chk("R6 xq set", xq_out, 1'b1);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 1'b0);
        chk("R8 xq cleared", xq_out, 1'b0);
        chk("R8 yq cleared", yq_out, 1'b0);
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0);

        // 5-variable function, R10
        f5 = 32'h8E3B_71D4;
        sx = xq_out;
        load(f5[15:0], f5[31:16], 8'hCA, 2'd2, 2'd0, 2'd2, 2'd1);
        chk("R9 xq held through load", xq_out, sx);
        for (int v = 0; v < 32; v++) begin
            run_cycle(1'b0, 1'b0, 1'b1, 1'b0, v[3:0], v[3:0], v[4]);
            cfg_en = 0; fa = v[3:0]; ga = v[3:0]; h1 = v[4]; #1;
            chk("R10 five-input x_out", x_out, f5[v]);
            chk("R10 five-input xq_out", xq_out, f5[v]);
        end

        // 9-input parity, R10
        load(16'h6996, 16'h6996, 8'h96, 2'd2, 2'd2, 2'd2, 2'd2);
        for (int v = 0; v < 512; v++) begin
            logic [8:0] w;
            w = 9'(v);
            run_cycle(1'b0, 1'b0, 1'b1, 1'b0, w[3:0], w[7:4], w[8]);
            cfg_en = 0; fa = w[3:0]; ga = w[7:4]; h1 = w[8]; #1;
            chk("R10 parity x_out", x_out, ^w);
            chk("R10 parity yq_out", yq_out, ^w);
        end

        // second reload: cfg_dout must replay the parity config (R2)
        load(16'h0F0F, 16'h3333, 8'h55, 2'd1, 2'd3, 2'd0, 2'd3);
        for (int n = 0; n < 64; n++) run_cycle(1'b0, 1'b0, n[1], n[5], 4'(n), 4'(n * 11), n[2]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule